// File: doc/BRIEF.md
# Presettable Binary Up Counter with Prioritised Controls

This block is a synchronous binary up counter, 12 bits wide by default, with a parallel preset and a decoded end-of-sequence flag. It is used where a known starting value must be forced into a running count, for example to divide a clock by a programmable amount or to count events up to a fixed limit. All three control inputs are active-low.

The controls follow a fixed ranking. The clear acts at once, without waiting for a clock edge, and overrides everything else. The load, sampled on the rising clock edge, takes effect next. Counting comes last. The count enable only gates the advance, so its level never changes what a clear or a load does. The flag is decoded from the registered count and is high while the count sits at its all-ones value. When the count steps past that value it wraps to zero.

Top module: `presettable_counter`

## Requirements
- R1: With clr_n high, load_n high and cnt_en_n low, each rising clock edge increases count by exactly one, modulo 2^12.
- R2: While clr_n is low, count is 0. The clear takes effect as soon as clr_n falls, without a clock edge, and it overrides every other control.
- R3: With clr_n high and load_n low, the rising clock edge copies data_in into count.
- R4: With clr_n high, load_n high and cnt_en_n high, count keeps its value across clock edges.
- R5: The level of cnt_en_n has no effect on a load or a clear. A load stores data_in and a clear gives 0, whether cnt_en_n is high or low.
- R6: term_cnt is 1 exactly when count equals 4095 (all twelve bits set) and 0 otherwise. While counting, it is high for one clock period in each pass through the sequence.
- R7: When count is 4095 and an enabled count edge occurs, count becomes 0 and term_cnt falls.
- R8: When clr_n and load_n are both low across a clock edge, count stays 0.
- R9: A change on load_n, cnt_en_n or data_in does not alter count until the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous actions happen on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear; highest priority |
| load_n | input | 1 | Active-low synchronous parallel load |
| data_in | input | 12 | Value copied into the counter on a load |
| cnt_en_n | input | 1 | Active-low count enable |
| count | output | 12 | Present counter value |
| term_cnt | output | 1 | High while count is at its last state, 4095 |

## Verification
The counter is preloaded with zero and then stepped through every one of the 4096 states and past the wrap. This pass checks the value after every edge and counts the cycles in which the flag is high, which catches both a wrong increment and a flag that is wide, missing or decoded from the wrong value. A set of preload values with alternating bit patterns (all zeros, all ones, alternating bits, and single-bit values) shows whether any data bit is stuck or crossed with another. Each of those loads is repeated with the enable both asserted and deasserted. The priority cases are tried with overlapping controls: clear with load, clear with enable, and load with enable. A clear dropped between clock edges shows whether the clear really acts without a clock edge. Changing the inputs half a cycle before an edge shows that nothing happens until that edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    localparam int unsigned CTR_W_DEF = 12;

    // Synchronous action selected for the next rising edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } ctr_op_e;

    // Active-high view of the synchronous requests
    typedef struct packed {
        logic load;
        logic step;
    } ctr_req_t;

    function automatic ctr_req_t to_req(input logic load_n, input logic en_n);
        ctr_req_t r;
        r.load = ~load_n;
        r.step = ~en_n;
        return r;
    endfunction

    // Load outranks counting; the enable only matters when no load is pending
    function automatic ctr_op_e rank_op(input ctr_req_t r);
        if (r.load)      return OP_LOAD;
        else if (r.step) return OP_STEP;
        else             return OP_HOLD;
    endfunction

endpackage

// File: rtl/ctr_op_sel.sv
module ctr_op_sel
    import ctr_pkg::*;
(
    input  logic    load_n,
    input  logic    cnt_en_n,
    output ctr_op_e op
);
    ctr_req_t req;

    always_comb begin
        req = to_req(load_n, cnt_en_n);
        op  = rank_op(req);
    end
endmodule

// File: rtl/ctr_next.sv
module ctr_next
    import ctr_pkg::*;
#(
    parameter int unsigned W = CTR_W_DEF
) (
    input  ctr_op_e        op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   data,
    output logic [W-1:0]   nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] inc;

    // Carry out of the top bit is dropped, giving the wrap to zero
    assign inc = cur + ONE;

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = data;
            OP_STEP: nxt = inc;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_tc_dec.sv
module ctr_tc_dec #(
    parameter int unsigned W = ctr_pkg::CTR_W_DEF
) (
    input  logic [W-1:0] cur,
    output logic         tc
);
    localparam logic [W-1:0] LAST = {W{1'b1}};

    assign tc = (cur == LAST);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import ctr_pkg::*;
#(
    parameter int unsigned W = CTR_W_DEF
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic [W-1:0] data_in,
    input  logic         cnt_en_n,
    output logic [W-1:0] count,
    output logic         term_cnt
);
    ctr_op_e      op;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    ctr_op_sel u_sel (
        .load_n   (load_n),
        .cnt_en_n (cnt_en_n),
        .op       (op)
    );

    ctr_next #(.W(W)) u_next (
        .op   (op),
        .cur  (cnt_q),
        .data (data_in),
        .nxt  (cnt_d)
    );

    // Clear acts without the clock and outranks every synchronous action
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    ctr_tc_dec #(.W(W)) u_tc (
        .cur (cnt_q),
        .tc  (term_cnt)
    );

    assign count = cnt_q;
endmodule

// File: rtl/counter_chk.sv
module counter_chk #(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic [W-1:0] data_in,
    input logic         cnt_en_n,
    input logic [W-1:0] count,
    input logic         term_cnt
);
    AST_CLEAR_ZERO: assert property (@(posedge clk)
        !clr_n |-> (count == '0 && !term_cnt)); // R2

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> count == $past(data_in)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !cnt_en_n) |=> count == W'($past(count) + W'(1))); // R1

    AST_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en_n) |=> $stable(count)); // R4

    AST_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
        (term_cnt && load_n && !cnt_en_n) |=> (count == '0 && !term_cnt)); // R7
endmodule

bind presettable_counter counter_chk #(.W(W)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .data_in  (data_in),
    .cnt_en_n (cnt_en_n),
    .count    (count),
    .term_cnt (term_cnt)
);

// File: tb/presettable_counter_bench.sv
`timescale 1ns/100ps
module presettable_counter_bench;
    localparam int W = 12;
    localparam logic [W-1:0] LAST = 12'hFFF;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         load_n = 1'b1;
    logic         cnt_en_n = 1'b1;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] count;
    logic         term_cnt;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    presettable_counter #(.W(W)) u_presettable_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_in),
        .cnt_en_n(cnt_en_n), .count(count), .term_cnt(term_cnt)
    );

    task automatic chk_val(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s count act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s term_cnt act=%0b exp=%0b", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the rising edge
    task automatic cyc(input logic ld, input logic en, input logic [W-1:0] d);
        @(negedge clk);
        load_n = ld; cnt_en_n = en; data_in = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [W-1:0] exp;
        int tc_seen;
        logic [W-1:0] pats [8];
        pats[0] = 12'h000; pats[1] = 12'hFFF; pats[2] = 12'hAAA; pats[3] = 12'h555;
        pats[4] = 12'h001; pats[5] = 12'h800; pats[6] = 12'h0F0; pats[7] = 12'hFFE;

        #1 clr_n = 1'b0;
        @(posedge clk); #1;
        chk_val("R2 reset", count, '0);
        chk_bit("R6 reset", term_cnt, 1'b0);
        @(negedge clk) clr_n = 1'b1;

        // Loads with both enable levels
        for (int i = 0; i < 8; i++) begin
            for (int e = 0; e < 2; e++) begin
                cyc(1'b0, e[0], pats[i]);
                chk_val("R3 R5 load", count, pats[i]);
                chk_bit("R6 after load", term_cnt, pats[i] == LAST);
            end
        end

        // Hold
        cyc(1'b0, 1'b1, 12'h123);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b1, 12'hFFF);
            chk_val("R4 hold", count, 12'h123);
        end

        // R9: inputs changed half a cycle before the edge do nothing yet
        @(negedge clk);
        load_n = 1'b0; data_in = 12'h777; cnt_en_n = 1'b0;
        #2;
        chk_val("R9 no edge", count, 12'h123);
        @(posedge clk); #1;
        chk_val("R9 at edge", count, 12'h777);

        // Full sweep from zero through the wrap
        cyc(1'b0, 1'b1, 12'h000);
        exp = '0;
        tc_seen = 0;
        for (int k = 0; k < 4097; k++) begin
            if (term_cnt) tc_seen++;
            cyc(1'b1, 1'b0, 12'h000);
            exp = exp + 1'b1;
            n_run++;
            if (count !== exp || term_cnt !== (exp == LAST)) begin
                n_fail++;
                $display("FAIL R1 R6 sweep act=%0h/%0b exp=%0h/%0b", count, term_cnt, exp, exp == LAST);
            end
        end
        n_run++;
        if (tc_seen != 1) begin
            n_fail++;
            $display("FAIL R6 flag cycles act=%0d exp=1", tc_seen);
        end

        // Wrap from a load of the last state
        cyc(1'b0, 1'b0, LAST);
        chk_bit("R6 at last", term_cnt, 1'b1);
        cyc(1'b1, 1'b0, 12'h000);
        chk_val("R7 wrap", count, 12'h000);
        chk_bit("R7 flag falls", term_cnt, 1'b0);

        // Async clear between edges, with enable active
        cyc(1'b0, 1'b1, 12'h5A5);
        @(negedge clk);
        load_n = 1'b1; cnt_en_n = 1'b0; clr_n = 1'b0;
        #1;
        chk_val("R2 async", count, '0);
        @(posedge clk); #1;
        chk_val("R5 clear with enable", count, '0);

        // Clear with load held across an edge
        @(negedge clk);
        load_n = 1'b0; data_in = 12'h9C3;
        @(posedge clk); #1;
        chk_val("R8 clear beats load", count, '0);
        @(negedge clk);
        clr_n = 1'b1; load_n = 1'b1; cnt_en_n = 1'b1;
        @(posedge clk); #1;
        chk_val("R8 after release", count, '0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule